// File: doc/BRIEF.md
# Indexed Register Access Port

This block is the host-facing window onto the register set of a hardware monitoring chip. A small parallel host bus sees two byte ports. One is an index port that holds a 7-bit pointer and reports a busy flag. The other is a data port that reads or writes whichever internal register the pointer selects. Accesses that land on the internal register file go out through a plain address, bank, write-strobe and read-strobe interface. Data returns combinationally from the register file.

The window also owns a few registers of its own. A control register holds a bank number, which picks the register set seen at indices 50h to 5Fh, and a byte-select flag. A read-only index returns one byte of a fixed 16-bit vendor code, chosen by that flag. A read-only chip identifier sits at 58h in bank 0. Over two index ranges the pointer steps forward by itself after every data-port access, so a host can sweep a block of monitor values without rewriting the index.

Top module: `mon_reg_window`

## Requirements
- R1: An access is recognised only while `cs_n` is 0 and `aen` is 0. The index port is offset 5 and the data port is offset 6. A read of any other offset returns 00h, and a write to any other offset changes nothing.
- R2: Reading the index port returns `{busy_in, ptr[6:0]}`. Writing it loads `ptr` from data bits 6:0 when the write strobe ends. After reset `ptr` is 00h.
- R3: When a data-port access ends with `ptr` in 20h–3Fh or 60h–7Fh, `ptr` advances by one. It goes from 3Fh to 40h and wraps from 7Fh to 00h.
- R4: When a data-port access ends with `ptr` outside those ranges, `ptr` keeps its value. The pointer also never changes except when an access ends.
- R5: The control register at index 4Eh holds the bank number in bits 2:0 and the byte-select flag in bit 7. Bits 6:3 read 0 and ignore writes. It resets to 00h, and `rf_bank` always shows the bank number.
- R6: Index 4Fh is read-only. It returns A3h when byte-select is 0 and 5Ch when byte-select is 1.
- R7: In bank 0, index 58h is read-only and returns 30h, and a write to it produces no `rf_wr`. In other banks, 58h belongs to the register file.
- R8: `rf_addr` equals `ptr`. A data-port read of a register-file index returns `rf_rdata` while the strobe is low, and one `rf_rd` pulse follows when the strobe ends. A data-port write produces exactly one `rf_wr` pulse, carrying the written byte, in the cycle after the strobe ends.
- R9: These indices are unmapped: 00h–1Fh, and 50h–5Fh while the bank number is 7 or more. A read of an unmapped index returns 00h, and an access to one produces no `rf_rd` or `rf_wr`.
- R10: `rdata` is 00h whenever no read strobe is recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| aen | input | 1 | Address enable; access only while low |
| addr | input | 3 | Port offset on the host bus |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| busy_in | input | 1 | Busy flag shown in index bit 7 |
| rf_addr | output | 7 | Register-file index |
| rf_bank | output | 3 | Register-file bank |
| rf_wdata | output | 8 | Register-file write data |
| rf_wr | output | 1 | Register-file write pulse |
| rf_rd | output | 1 | Register-file read-done pulse |
| rf_rdata | input | 8 | Register-file read data |

## Verification
The bound checker watches several things on every cycle. The pointer may move only when an access ends, and then only by one inside the stepping ranges. The bank may change only after a write ends. The `rf_wr` strobe is always a single pulse that follows a write strobe. `rdata` stays 00h outside reads, and the busy bit always matches on index reads. Only the bench scenarios can show the right values: the bank, byte-select and identifier mappings, the unmapped ranges, and the 3Fh and 7Fh step boundaries. They also show that ignored writes leave state unchanged.

// File: rtl/mon_reg_window.sv
module mon_reg_window #(
  parameter int          BANK_W     = 3,
  parameter int          BANK_COUNT = 7,
  parameter logic [2:0]  IDX_PORT   = 3'd5,
  parameter logic [2:0]  DAT_PORT   = 3'd6,
  parameter logic [15:0] VENDOR_ID  = 16'h5CA3,
  parameter logic [7:0]  CHIP_ID    = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              aen,
  input  logic [2:0]        addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              busy_in,
  output logic [6:0]        rf_addr,
  output logic [BANK_W-1:0] rf_bank,
  output logic [7:0]        rf_wdata,
  output logic              rf_wr,
  output logic              rf_rd,
  input  logic [7:0]        rf_rdata
);
  localparam logic [6:0] CTRL_IDX = 7'h4E;
  localparam logic [6:0] VID_IDX  = 7'h4F;
  localparam logic [6:0] CID_IDX  = 7'h58;
  localparam logic [6:0] RF_BASE  = 7'h20;
  localparam logic [BANK_W:0] BANK_LIM = BANK_COUNT[BANK_W:0];

  logic [6:0]        ptr;
  logic [BANK_W-1:0] bank;
  logic              bsel;
  logic              rd_q, wr_q;
  logic [2:0]        off_q;
  logic [7:0]        wd_q;

  wire sel    = !cs_n && !aen;
  wire rd_now = sel && !rd_n;
  wire wr_now = sel && !wr_n && rd_n;
  wire rd_end = rd_q && !rd_now;
  wire wr_end = wr_q && !wr_now;
  wire idx_q  = off_q == IDX_PORT;
  wire dat_q  = off_q == DAT_PORT;

  wire in_win   = ptr[6:4] == 3'b101;
  wire bank_ok  = {1'b0, bank} < BANK_LIM;
  wire is_ctrl  = ptr == CTRL_IDX;
  wire is_vid   = ptr == VID_IDX;
  wire is_cid   = (ptr == CID_IDX) && (bank == '0);
  wire auto_inc = ptr[5];
  wire rf_hit   = (ptr >= RF_BASE) && !is_ctrl && !is_vid && !is_cid
                  && !(in_win && !bank_ok);

  logic [7:0] dat_val;
  always_comb begin
    if (is_ctrl)     dat_val = {bsel, {(7-BANK_W){1'b0}}, bank};
    else if (is_vid) dat_val = bsel ? VENDOR_ID[15:8] : VENDOR_ID[7:0];
    else if (is_cid) dat_val = CHIP_ID;
    else if (rf_hit) dat_val = rf_rdata;
    else             dat_val = 8'h00;
  end

  assign rdata = !rd_now            ? 8'h00 :
                 (addr == IDX_PORT) ? {busy_in, ptr} :
                 (addr == DAT_PORT) ? dat_val : 8'h00;

  assign rf_addr  = ptr;
  assign rf_bank  = bank;
  assign rf_wdata = wd_q;
  assign rf_wr    = wr_end && dat_q && rf_hit;
  assign rf_rd    = rd_end && dat_q && rf_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      off_q <= '0;
      wd_q  <= '0;
    end else begin
      rd_q <= rd_now;
      wr_q <= wr_now;
      if (rd_now || wr_now) begin
        off_q <= addr;
        wd_q  <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (wr_end && idx_q) ptr <= wd_q[6:0];
    else if ((rd_end || wr_end) && dat_q && auto_inc) ptr <= ptr + 7'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= '0;
      bsel <= 1'b0;
    end else if (wr_end && dat_q && is_ctrl) begin
      bank <= wd_q[BANK_W-1:0];
      bsel <= wd_q[7];
    end
  end
endmodule

// File: rtl/mon_reg_window_chk.sv
module mon_reg_window_chk #(
  parameter int         BANK_W   = 3,
  parameter logic [2:0] IDX_PORT = 3'd5,
  parameter logic [2:0] DAT_PORT = 3'd6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              aen,
  input logic [2:0]        addr,
  input logic              rd_n,
  input logic              wr_n,
  input logic [7:0]        rdata,
  input logic              busy_in,
  input logic              rf_wr,
  input logic [BANK_W-1:0] rf_bank,
  input logic [6:0]        ptr
);
  logic c_rd_q, c_wr_q;
  logic [2:0] c_off;
  wire c_rd  = !cs_n && !aen && !rd_n;
  wire c_wr  = !cs_n && !aen && !wr_n && rd_n;
  wire c_end = (c_rd_q && !c_rd) || (c_wr_q && !c_wr);
  wire c_dend = c_end && (c_off == DAT_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_rd_q <= 1'b0;
      c_wr_q <= 1'b0;
      c_off  <= '0;
    end else begin
      c_rd_q <= c_rd;
      c_wr_q <= c_wr;
      if (c_rd || c_wr) c_off <= addr;
    end
  end

  a_r10_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rd |-> rdata == 8'h00);
  a_r2_busy_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd && addr == IDX_PORT) |-> rdata[7] == busy_in);
  a_r4_ptr_only_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    !c_end |=> $stable(ptr));
  a_r4_ptr_hold_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (c_dend && !ptr[5]) |=> $stable(ptr));
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (c_dend && ptr[5]) |=> ptr == $past(ptr) + 7'd1);
  a_r5_bank_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_wr_q && !c_wr) |=> $stable(rf_bank));
  a_r8_wr_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> (c_wr_q && !c_wr));
  a_r8_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> !rf_wr);
endmodule

bind mon_reg_window mon_reg_window_chk #(
  .BANK_W(BANK_W), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .aen(aen), .addr(addr),
  .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata), .busy_in(busy_in),
  .rf_wr(rf_wr), .rf_bank(rf_bank), .ptr(ptr)
);

// File: tb/tb_mon_reg_window.sv
module tb_mon_reg_window;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, aen = 1'b0, rd_n = 1'b1, wr_n = 1'b1, busy_in = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, rf_wdata, rf_rdata;
  logic [6:0] rf_addr;
  logic [2:0] rf_bank;
  logic rf_wr, rf_rd;
  int checks = 0, fails = 0, n_wr = 0, n_rd = 0;
  bit done = 1'b0;

  logic [7:0] mem [0:7][0:127];

  always #2.5 clk = ~clk;

  mon_reg_window dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .aen(aen), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata), .busy_in(busy_in),
    .rf_addr(rf_addr), .rf_bank(rf_bank), .rf_wdata(rf_wdata),
    .rf_wr(rf_wr), .rf_rd(rf_rd), .rf_rdata(rf_rdata)
  );

  assign rf_rdata = mem[rf_bank][rf_addr];

  always @(posedge clk) begin
    if (rf_wr) begin
      mem[rf_bank][rf_addr] <= rf_wdata;
      n_wr <= n_wr + 1;
    end
    if (rf_rd) n_rd <= n_rd + 1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic access(input bit is_rd, input logic [2:0] off, input logic [7:0] d,
                        output logic [7:0] got, input bit csn = 1'b0, input bit en = 1'b0);
    @(negedge clk);
    cs_n = csn; aen = en; addr = off; wdata = d;
    if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    got = rdata;
    rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    logic [7:0] g;
    access(1'b0, off, d, g);
  endtask

  task automatic rd_chk(input logic [2:0] off, input logic [7:0] exp, input string req);
    logic [7:0] g;
    access(1'b1, off, 8'h00, g);
    check(req, g, exp);
  endtask

  localparam logic [19:0] VEC [12] = '{
    20'h5_20_00, 20'h6_11_00, 20'h6_22_00, 20'hD_00_22,
    20'h5_20_00, 20'hE_00_11, 20'hE_00_22, 20'h5_40_00,
    20'h6_33_00, 20'hD_00_40, 20'hE_00_33, 20'hD_00_40
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    int c0;
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < 128; i++) mem[b][i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R10 idle rdata", rdata, 8'h00);
    rd_chk(3'd5, 8'h00, "R2 reset index");
    check("R5 reset bank", {5'b0, rf_bank}, 8'h00);

    // R2 R3 R4 R8 vector walk
    for (int v = 0; v < 12; v++) begin
      logic [3:0] op;
      op = VEC[v][19:16];
      access(op[3], op[2:0], VEC[v][15:8], g);
      if (op[3]) check($sformatf("R3 R4 R8 vector %0d", v), g, VEC[v][7:0]);
    end

    busy_in = 1'b1;
    rd_chk(3'd5, 8'hC0, "R2 busy bit");
    busy_in = 1'b0;

    wr(3'd5, 8'h7F); wr(3'd6, 8'h55);
    rd_chk(3'd5, 8'h00, "R3 wrap 7F");
    wr(3'd5, 8'h7F); rd_chk(3'd6, 8'h55, "R8 read 7F");
    wr(3'd5, 8'h3F); rd_chk(3'd6, 8'h00, "R8 read 3F");
    rd_chk(3'd5, 8'h40, "R3 step 3F");

    access(1'b0, 3'd5, 8'h10, g, 1'b1, 1'b0);
    rd_chk(3'd5, 8'h40, "R1 cs_n high");
    access(1'b0, 3'd5, 8'h10, g, 1'b0, 1'b1);
    rd_chk(3'd5, 8'h40, "R1 aen high");
    access(1'b1, 3'd5, 8'h00, g, 1'b1, 1'b0);
    check("R1 deselected read", g, 8'h00);
    rd_chk(3'd2, 8'h00, "R1 other offset");
    wr(3'd7, 8'h05);
    rd_chk(3'd5, 8'h40, "R1 other offset write");

    wr(3'd5, 8'h4E); wr(3'd6, 8'h83);
    rd_chk(3'd6, 8'h83, "R5 ctrl read");
    check("R5 rf_bank", {5'b0, rf_bank}, 8'h03);
    wr(3'd6, 8'hFF);
    rd_chk(3'd6, 8'h87, "R5 reserved bits");
    rd_chk(3'd5, 8'h4E, "R4 no step at 4E");
    wr(3'd6, 8'h81);
    wr(3'd5, 8'h4F);
    rd_chk(3'd6, 8'h5C, "R6 high byte");
    wr(3'd6, 8'h00);
    rd_chk(3'd6, 8'h5C, "R6 write ignored");
    wr(3'd5, 8'h4E); wr(3'd6, 8'h00);
    wr(3'd5, 8'h4F);
    rd_chk(3'd6, 8'hA3, "R6 low byte");

    wr(3'd5, 8'h58);
    rd_chk(3'd6, 8'h30, "R7 chip id");
    c0 = n_wr;
    wr(3'd6, 8'h99);
    check("R7 no rf_wr", 8'(n_wr - c0), 8'h00);
    rd_chk(3'd6, 8'h30, "R7 still 30");

    wr(3'd5, 8'h4E); wr(3'd6, 8'h01);
    wr(3'd5, 8'h58);
    c0 = n_wr;
    wr(3'd6, 8'h44);
    check("R8 one rf_wr", 8'(n_wr - c0), 8'h01);
    rd_chk(3'd6, 8'h44, "R7 bank1 58");
    check("R8 bank1 store", mem[1][7'h58], 8'h44);

    wr(3'd5, 8'h4E); wr(3'd6, 8'h07);
    wr(3'd5, 8'h55);
    c0 = n_wr;
    wr(3'd6, 8'h66);
    check("R9 bank7 no rf_wr", 8'(n_wr - c0), 8'h00);
    c0 = n_rd;
    rd_chk(3'd6, 8'h00, "R9 bank7 read");
    check("R9 bank7 no rf_rd", 8'(n_rd - c0), 8'h00);

    wr(3'd5, 8'h4E); wr(3'd6, 8'h00);
    wr(3'd5, 8'h10);
    c0 = n_rd;
    rd_chk(3'd6, 8'h00, "R9 low index");
    check("R9 low no rf_rd", 8'(n_rd - c0), 8'h00);

    wr(3'd5, 8'h20);
    c0 = n_rd;
    rd_chk(3'd6, 8'h11, "R8 mapped read");
    check("R8 one rf_rd", 8'(n_rd - c0), 8'h01);
    check("R10 idle after", rdata, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule